// File: doc/BRIEF.md
# Self-Loading Rotating Ring Sequencer

This block walks a lit bit pattern around a small ring of LED outputs at a rate a person can follow. It runs on the fast system clock. A free-running divider produces a one-cycle advance strobe once every 2^DIV_LOG2 cycles. Every state change in the block happens only on clock edges where that strobe is high.

The core is a register that can either load its parallel input or shift. A one-shot initializer chooses between the two. After reset it selects load, so the first strobed edge copies the `init_pattern` input into the register. From then on it selects shift, until the next reset. During a shift the top bit of the register feeds back into the bottom, so the pattern rotates toward the most significant end and no bit is lost.

In normal use `init_pattern` is tied to 0001. That gives the repeating sequence 0001, 0010, 0100, 1000. The register value drives the LEDs directly. The advance strobe is also brought out so the motion can be observed.

Top module: `ring_sequencer`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block clears `leds` to all zeros and drives `tick` low in the following cycle.
- R2: `tick` is high for exactly one cycle in every 2^DIV_LOG2 cycles. After reset is released, its first high cycle follows the 2^DIV_LOG2 − 1-th rising edge.
- R3: On the first clock edge after reset where `tick` is high, `leds` takes the value of `init_pattern`.
- R4: On every later edge where `tick` is high, `leds` rotates toward the most significant end. Bit i moves to bit i+1, and the old most significant bit enters bit 0.
- R5: On edges where `tick` is low, `leds` keeps its value.
- R6: Once the load has happened, changes on `init_pattern` have no effect on `leds` until the next reset.
- R7: An all-zero loaded pattern keeps `leds` at 0000. A pattern with several ones keeps its number of ones and their spacing as it rotates.
- R8: With `init_pattern` = 0001, successive strobed edges give 0001, 0010, 0100, 1000, then 0001 again.
- R9: A reset applied in the middle of a run restarts the divider and the load-then-rotate sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_pattern | input | WIDTH | Value loaded once on the first strobed edge (normally 0001) |
| leds | output | WIDTH | Register value driving the LEDs |
| tick | output | 1 | One-cycle advance strobe from the divider |

## Verification
`tick` comes combinationally from the divider count register. It is therefore high in the cycle that follows the (2^DIV_LOG2 − 1)-th edge after reset release. `leds` changes one edge later than that, at the edge where `tick` is sampled high. Reset takes effect on the first edge where it is sampled low. The bench drives inputs on falling edges. It advances a behavioural model of the counter, the load flag and the ring on each rising edge, and compares both outputs with the model on the next falling edge. Every result is therefore checked in exactly the cycle it is due. The per-step checks on the default sequence count four falling edges for each strobe period.

// File: rtl/ring_seq_pkg.sv
// Package: shared types for the ring sequencer.
// Assumes: nothing; holds only the register mode encoding.
package ring_seq_pkg;
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } reg_mode_e;
endpackage

// File: rtl/rs_prescaler.sv
// Module: rs_prescaler
// A free-running counter of DIV_LOG2 bits. It raises `adv` for one cycle
// whenever the count is at its maximum, so `adv` recurs every 2^DIV_LOG2 cycles.
// Assumes: DIV_LOG2 >= 1; rst_n is synchronous and active low.
module rs_prescaler #(
    parameter int DIV_LOG2 = 22
) (
    input  logic clk,
    input  logic rst_n,
    output logic adv
);
    localparam int CW = DIV_LOG2;

    logic [CW-1:0] count_q;

    // Count up on every cycle and clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + 1'b1;
    end

    // Strobe while the count is at its top value.
    always_comb adv = &count_q;
endmodule

// File: rtl/rs_oneshot_init.sv
// Module: rs_oneshot_init
// The power-up mode selector. It reports MODE_LOAD until the first enabled
// edge after reset, then reports MODE_SHIFT until the next reset.
// Assumes: `en` is a one-cycle clock-enable strobe.
module rs_oneshot_init
    import ring_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    output reg_mode_e mode,
    output logic      done
);
    logic done_q;

    // Set the flag on the first enabled edge; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  done_q <= 1'b0;
        else if (en) done_q <= 1'b1;
    end

    // Map the flag onto the register mode.
    always_comb begin
        done = done_q;
        mode = done_q ? MODE_SHIFT : MODE_LOAD;
    end
endmodule

// File: rtl/rs_shift_reg.sv
// Module: rs_shift_reg
// A WIDTH-bit register with a parallel-load mode and a shift mode. A shift
// drops the top bit, moves each other bit up one place and puts `ser_in` at bit 0.
// It updates only when `en` is high.
// Assumes: WIDTH >= 2; rst_n is synchronous and active low.
module rs_shift_reg
    import ring_seq_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  reg_mode_e        mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] next_d;

    // Select the next value of each bit from the mode and the bit's neighbour.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            always_comb next_d[i] = (mode == MODE_LOAD) ? par_in[i] : ser_in;
        end else begin : g_up
            always_comb next_d[i] = (mode == MODE_LOAD) ? par_in[i] : q_r[i-1];
        end
    end

    // Capture the selected value on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)  q_r <= '0;
        else if (en) q_r <= next_d;
    end

    // Drive the output.
    always_comb q = q_r;
endmodule

// File: rtl/ring_sequencer.sv
// Module: ring_sequencer (top)
// Connects the divider, the one-shot initializer and the load/shift register.
// The register's top bit feeds its serial input, so the loaded pattern rotates.
// Assumes: one clock domain; the divider strobe serves as a clock enable.
module ring_sequencer
    import ring_seq_pkg::*;
#(
    parameter int WIDTH    = 4,
    parameter int DIV_LOG2 = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] init_pattern,
    output logic [WIDTH-1:0] leds,
    output logic             tick
);
    localparam int MSB = WIDTH - 1;

    logic             adv;
    logic             init_done;
    reg_mode_e        mode;
    logic [WIDTH-1:0] ring_q;

    rs_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv)
    );

    rs_oneshot_init u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (adv),
        .mode  (mode),
        .done  (init_done)
    );

    rs_shift_reg #(.WIDTH(WIDTH)) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (adv),
        .mode   (mode),
        .par_in (init_pattern),
        .ser_in (ring_q[MSB]),
        .q      (ring_q)
    );

    // Drive the outputs.
    always_comb begin
        leds = ring_q;
        tick = adv;
    end
endmodule

// File: rtl/ring_sequencer_checks.sv
// Module: ring_sequencer_checks
// Temporal properties for ring_sequencer, attached through bind.
// Assumes: DIV_LOG2 >= 1, so two strobes are never adjacent.
module ring_sequencer_checks #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] init_pattern,
    input logic [WIDTH-1:0] leds,
    input logic             tick,
    input logic             loaded
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (leds == '0 && !tick));

    p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_first_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !loaded) |=> (leds == $past(init_pattern)));

    p_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && loaded) |=> (leds == {$past(leds[WIDTH-2:0]), $past(leds[WIDTH-1])}));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(leds));

    p_load_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded);

    p_ones_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && loaded) |=> ($countones(leds) == $countones($past(leds))));
endmodule

bind ring_sequencer ring_sequencer_checks #(.WIDTH(WIDTH)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_pattern (init_pattern),
    .leds         (leds),
    .tick         (tick),
    .loaded       (init_done)
);

// File: tb/test_ring_sequencer.sv
module test_ring_sequencer;
    localparam int W   = 4;
    localparam int K   = 2;
    localparam int DIV = 1 << K;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] init_pattern = 4'b0001;
    logic [W-1:0] leds;
    logic         tick;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string ph_tag = "R1";
    string ev_tag = "R1";

    // Behavioural reference state.
    int           m_cnt = 0;
    bit           m_loaded = 0;
    logic [W-1:0] m_q = '0;

    ring_sequencer #(.WIDTH(W), .DIV_LOG2(K)) i_ring_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_pattern (init_pattern),
        .leds         (leds),
        .tick         (tick)
    );

    always #5 clk = ~clk;

    // Reference model: advance on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_loaded = 0; m_q = '0; ev_tag = "R1";
        end else begin
            if (m_cnt == DIV - 1) begin
                if (!m_loaded) begin
                    m_q = init_pattern; m_loaded = 1; ev_tag = "R3";
                end else begin
                    m_q = {m_q[W-2:0], m_q[W-1]}; ev_tag = "R4";
                end
            end else begin
                ev_tag = "R5";
            end
            m_cnt = (m_cnt + 1) % DIV;
        end
    end

    // Compare with the model on every falling edge.
    always @(negedge clk) begin
        checks++;
        if (leds !== m_q) begin
            failures++;
            $display("FAIL %s/%s leds actual=%b expected=%b t=%0t", ev_tag, ph_tag, leds, m_q, $time);
        end
        checks++;
        if (tick !== (m_cnt == DIV - 1)) begin
            failures++;
            $display("FAIL R2/%s tick actual=%b expected=%b t=%0t", ph_tag, tick, (m_cnt == DIV - 1), $time);
        end
    end

    task automatic check_val(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s leds actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [W-1:0] pat);
        @(negedge clk);
        rst_n = 1'b0;
        init_pattern = pat;
        repeat (2) @(negedge clk);
        check_val("R1", leds, '0);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: default pattern walks through the four positions.
        ph_tag = "R8";
        do_reset(4'b0001);
        begin
            logic [W-1:0] seq [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0001};
            for (int s = 0; s < 5; s++) begin
                repeat (DIV) @(negedge clk);
                check_val("R8", leds, seq[s]);
            end
        end
        repeat (12) @(negedge clk);

        // R6: pattern changes after the load are ignored.
        ph_tag = "R6";
        init_pattern = 4'b1111;
        repeat (20) @(negedge clk);
        init_pattern = 4'b0110;
        repeat (9) @(negedge clk);

        // R7: an all-zero pattern stays dark.
        ph_tag = "R7";
        do_reset(4'b0000);
        repeat (24) @(negedge clk);
        check_val("R7", leds, 4'b0000);

        // R7: several ones keep their spacing.
        do_reset(4'b0101);
        repeat (DIV) @(negedge clk);
        check_val("R7", leds, 4'b0101);
        repeat (DIV) @(negedge clk);
        check_val("R7", leds, 4'b1010);
        repeat (22) @(negedge clk);

        // R9: reset part way through a run restarts the sequence.
        ph_tag = "R9";
        init_pattern = 4'b1001;
        repeat (3) @(negedge clk);
        do_reset(4'b1001);
        repeat (DIV) @(negedge clk);
        check_val("R9", leds, 4'b1001);
        repeat (DIV) @(negedge clk);
        check_val("R9", leds, 4'b0011);
        repeat (30) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule